// File: doc/BRIEF.md
# SDRAM Bank Timing Rule Monitor

This block sits beside an SDRAM command bus and watches every command placed on it. On each rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins into activate, precharge, read, write or "no tracked command". It keeps a small record per bank: whether the bank is open, cycles since its last activate, and cycles since its last precharge. It also keeps two bus-wide records: cycles since the most recent activate to any bank, and cycles since the most recent column command. Every tracked command is then checked against six minimum-spacing rules and one bank-state rule.

The timing limits and the additive latency are inputs, so one instance serves any speed grade. The activate-to-column rule counts from when a posted column command takes effect inside the memory. That point is its issue cycle plus the additive latency, so a column command may appear on the pins early without being flagged.

The result of each command is registered. It appears as a one-bit violation flag and a three-bit reason code on the cycle after the command is sampled. Refresh, mode programming, power-down and data transfers are not tracked.

Top module: `sdram_timing_checker`

## Requirements
- R1: With cs_n low, the pin pattern ras_n=0, cas_n=1 is an activate when we_n=1 and a precharge when we_n=0. The pattern ras_n=1, cas_n=0 is a read when we_n=1 and a write when we_n=0. Any other pattern, or cs_n high, is ignored: it produces reason 0 and changes no tracked state.
- R2: The flag and reason for a command sampled at a rising edge are registered at that edge and hold until the next edge. viol is 1 exactly when reason is nonzero.
- R3: A read or write to an open bank reports reason 1 when the cycles since that bank's activate, plus add_lat, are less than t_rcd.
- R4: An activate reports reason 2 when it targets a different bank from the most recent activate and comes fewer than t_rrd cycles after it.
- R5: A read or write reports reason 3 when it comes fewer than t_ccd cycles after the previous read or write to any bank.
- R6: A precharge to an open bank reports reason 4 when it comes fewer than t_ras cycles after that bank's activate.
- R7: An activate reports reason 5 when it comes fewer than t_rp cycles after a precharge to the same bank.
- R8: An activate reports reason 6 when it comes fewer than t_rc cycles after the previous activate to the same bank.
- R9: A read, write or precharge to a bank that is not open reports reason 7.
- R10: When several rules fail on one command, the smallest nonzero code is reported.
- R11: After reset, all banks are idle and all cycle counts are at their ceiling. The outputs are 0, and the first activate to any bank reports reason 0.
- R12: Every decoded command updates the tracked state, even if it is flagged. An activate opens its bank and restarts its counts. A precharge closes its bank and restarts its recovery count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Target bank index |
| t_rcd | input | CNT_W | Activate-to-column minimum (internal) |
| t_rrd | input | CNT_W | Activate-to-activate minimum, different banks |
| t_ccd | input | CNT_W | Column-to-column minimum |
| t_ras | input | CNT_W | Activate-to-precharge minimum |
| t_rp | input | CNT_W | Precharge-to-activate minimum |
| t_rc | input | CNT_W | Activate-to-activate minimum, same bank |
| add_lat | input | CNT_W | Additive latency of posted column commands |
| viol | output | 1 | Previous sampled command broke a rule |
| reason | output | 3 | Code of the rule broken (0 none, 1 to 7) |

## Verification
Each command's verdict is due exactly one rising edge after the command is sampled. The bench drives pins on a falling edge and reads viol and reason on the next falling edge, half a cycle after the result is registered. The gap between two commands equals the number of idle cycles placed between them plus one. Each sweep steps that gap across the threshold of one rule, so the expected code follows by comparing the gap with the configured limit. Each sweep starts from reset so that only the intended history applies.

// File: rtl/sdram_chk_pkg.sv
// Shared types for the SDRAM timing rule monitor: decoded command kinds
// and violation reason codes. The numeric reason values are visible at
// the top-level port, and their order sets the reporting priority.
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        RSN_NONE   = 3'd0,
        RSN_RCD    = 3'd1,
        RSN_RRD    = 3'd2,
        RSN_CCD    = 3'd3,
        RSN_RAS    = 3'd4,
        RSN_RP     = 3'd5,
        RSN_RC     = 3'd6,
        RSN_CLOSED = 3'd7
    } reason_e;

    // True for read or write.
    function automatic logic is_column(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder. Maps the four active-low control pins onto a tracked
// command kind. Assumes the pins are stable around the sampling edge.
// Patterns that are not tracked (refresh, mode programming, burst stop,
// deselect) map to CMD_NOP.
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Pin pattern to command kind.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n})
                2'b01:   cmd = we_n ? CMD_ACT : CMD_PRE;
                2'b10:   cmd = we_n ? CMD_RD  : CMD_WR;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_sat_counter.sv
// Saturating "cycles since event" counter. A restart pulse sets the count
// so that it reads 1 on the following edge. The count then climbs by one
// per cycle and stops at all-ones. Reset parks it at all-ones, meaning
// "long ago", so no rule can fire against it.
module sdram_sat_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CEIL = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    // Restart, advance or hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= CEIL;
        else if (restart)
            count <= ONE;
        else if (count != CEIL)
            count <= count + ONE;
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
// State for one bank: the open flag, cycles since its last activate and
// cycles since its last precharge. Assumes at most one of act_hit and
// pre_hit is high in a cycle. Flagged commands still update the state.
module sdram_bank_tracker #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_hit,
    input  logic             pre_hit,
    output logic             is_open,
    output logic [CNT_W-1:0] since_act,
    output logic [CNT_W-1:0] since_pre
);

    // Open flag: set by activate, cleared by precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_open <= 1'b0;
        else if (act_hit)
            is_open <= 1'b1;
        else if (pre_hit)
            is_open <= 1'b0;
    end

    sdram_sat_counter #(.W(CNT_W)) u_act_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (act_hit),
        .count   (since_act)
    );

    sdram_sat_counter #(.W(CNT_W)) u_pre_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pre_hit),
        .count   (since_pre)
    );

endmodule

// File: rtl/sdram_rule_arbiter.sv
// Combinational rule evaluation for the command currently on the pins.
// It takes the selected bank's state and the bus-wide ages, tests every
// spacing rule, and returns the smallest failing reason code. The
// activate-to-column rule adds the additive latency to the measured gap.
module sdram_rule_arbiter
    import sdram_chk_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  cmd_e             cmd,
    input  logic             bank_open,
    input  logic [CNT_W-1:0] bank_since_act,
    input  logic [CNT_W-1:0] bank_since_pre,
    input  logic [CNT_W-1:0] any_since_act,
    input  logic             other_bank,
    input  logic [CNT_W-1:0] any_since_col,
    input  logic [CNT_W-1:0] t_rcd,
    input  logic [CNT_W-1:0] t_rrd,
    input  logic [CNT_W-1:0] t_ccd,
    input  logic [CNT_W-1:0] t_ras,
    input  logic [CNT_W-1:0] t_rp,
    input  logic [CNT_W-1:0] t_rc,
    input  logic [CNT_W-1:0] add_lat,
    output reason_e          reason
);

    localparam int SW = CNT_W + 1;

    logic          col, act, pre;
    logic [SW-1:0] eff_gap;
    logic          f_rcd, f_rrd, f_ccd, f_ras, f_rp, f_rc, f_closed;

    // Command class strobes.
    always_comb begin
        col = is_column(cmd);
        act = (cmd == CMD_ACT);
        pre = (cmd == CMD_PRE);
    end

    // Internal activate-to-column gap, widened so the sum cannot wrap.
    always_comb eff_gap = {1'b0, bank_since_act} + {1'b0, add_lat};

    // Individual rule tests.
    always_comb begin
        f_rcd    = col && bank_open && (eff_gap < {1'b0, t_rcd});
        f_rrd    = act && other_bank && (any_since_act < t_rrd);
        f_ccd    = col && (any_since_col < t_ccd);
        f_ras    = pre && bank_open && (bank_since_act < t_ras);
        f_rp     = act && (bank_since_pre < t_rp);
        f_rc     = act && (bank_since_act < t_rc);
        f_closed = (col || pre) && !bank_open;
    end

    // Lowest failing code wins.
    always_comb begin
        if      (f_rcd)    reason = RSN_RCD;
        else if (f_rrd)    reason = RSN_RRD;
        else if (f_ccd)    reason = RSN_CCD;
        else if (f_ras)    reason = RSN_RAS;
        else if (f_rp)     reason = RSN_RP;
        else if (f_rc)     reason = RSN_RC;
        else if (f_closed) reason = RSN_CLOSED;
        else               reason = RSN_NONE;
    end

endmodule

// File: rtl/sdram_timing_checker.sv
// SDRAM command-spacing monitor, top level. It decodes the control pins,
// keeps per-bank and bus-wide age counters, evaluates the rules for the
// command on the pins, and registers a flag and reason one edge later.
// Assumes the timing inputs are held steady while commands are monitored
// and that every limit is below the counter ceiling (2**CNT_W - 1).
module sdram_timing_checker
    import sdram_chk_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [CNT_W-1:0]  t_rcd,
    input  logic [CNT_W-1:0]  t_rrd,
    input  logic [CNT_W-1:0]  t_ccd,
    input  logic [CNT_W-1:0]  t_ras,
    input  logic [CNT_W-1:0]  t_rp,
    input  logic [CNT_W-1:0]  t_rc,
    input  logic [CNT_W-1:0]  add_lat,
    output logic              viol,
    output logic [2:0]        reason
);

    localparam int NUM_BANKS = 1 << BANK_W;

    cmd_e              cmd;
    logic              cmd_act, cmd_pre, cmd_col;
    logic [NUM_BANKS-1:0] act_hit, pre_hit, bank_open;
    logic [CNT_W-1:0]  bank_since_act [NUM_BANKS];
    logic [CNT_W-1:0]  bank_since_pre [NUM_BANKS];
    logic [CNT_W-1:0]  any_since_act, any_since_col;
    logic [BANK_W-1:0] last_act_bank;
    reason_e           verdict;

    sdram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    // Command class strobes for the trackers.
    always_comb begin
        cmd_act = (cmd == CMD_ACT);
        cmd_pre = (cmd == CMD_PRE);
        cmd_col = is_column(cmd);
    end

    // One tracker per bank, each steered by its own one-hot hit.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            act_hit[b] = cmd_act && (bank == BANK_W'(b));
            pre_hit[b] = cmd_pre && (bank == BANK_W'(b));
        end

        sdram_bank_tracker #(.CNT_W(CNT_W)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_hit   (act_hit[b]),
            .pre_hit   (pre_hit[b]),
            .is_open   (bank_open[b]),
            .since_act (bank_since_act[b]),
            .since_pre (bank_since_pre[b])
        );
    end

    // Bus-wide age of the most recent activate.
    sdram_sat_counter #(.W(CNT_W)) u_any_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cmd_act),
        .count   (any_since_act)
    );

    // Bus-wide age of the most recent read or write.
    sdram_sat_counter #(.W(CNT_W)) u_any_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cmd_col),
        .count   (any_since_col)
    );

    // Remember which bank took the most recent activate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_act_bank <= '0;
        else if (cmd_act)
            last_act_bank <= bank;
    end

    sdram_rule_arbiter #(.CNT_W(CNT_W)) u_rules (
        .cmd            (cmd),
        .bank_open      (bank_open[bank]),
        .bank_since_act (bank_since_act[bank]),
        .bank_since_pre (bank_since_pre[bank]),
        .any_since_act  (any_since_act),
        .other_bank     (bank != last_act_bank),
        .any_since_col  (any_since_col),
        .t_rcd          (t_rcd),
        .t_rrd          (t_rrd),
        .t_ccd          (t_ccd),
        .t_ras          (t_ras),
        .t_rp           (t_rp),
        .t_rc           (t_rc),
        .add_lat        (add_lat),
        .reason         (verdict)
    );

    // Register the verdict for the command just sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol   <= 1'b0;
            reason <= 3'd0;
        end else begin
            viol   <= (verdict != RSN_NONE);
            reason <= verdict;
        end
    end

endmodule

// File: rtl/sdram_timing_checker_sva.sv
// Property checker for the SDRAM timing monitor, bound onto every
// instance of the top. It re-decodes the pins on its own and relates the
// command stream to the registered verdict one edge later.
module sdram_timing_checker_sva #(
    parameter int BANK_W = 2,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] bank,
    input logic [CNT_W-1:0]  t_rrd,
    input logic [CNT_W-1:0]  t_ccd,
    input logic              viol,
    input logic [2:0]        reason
);

    logic is_act, is_pre, is_col, any_cmd, seen_cmd;

    // Local decode of the pins.
    always_comb begin
        is_act  = !cs_n && !ras_n &&  cas_n &&  we_n;
        is_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
        is_col  = !cs_n &&  ras_n && !cas_n;
        any_cmd = is_act || is_pre || is_col;
    end

    // Marks whether any tracked command has arrived since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_cmd <= 1'b0;
        else if (any_cmd)
            seen_cmd <= 1'b1;
    end

    assert_flag_matches_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        viol == (reason != 3'd0));

    assert_ignored_pattern_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cmd |=> (!viol && reason == 3'd0));

    assert_column_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_col ##1 (is_col && t_ccd >= CNT_W'(2)) |=> viol);

    assert_activate_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_act ##1 (is_act && bank != $past(bank) && t_rrd >= CNT_W'(2)) |=> viol);

    assert_first_activate_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_cmd && is_act) |=> !viol);

    assert_closed_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_cmd && is_pre) |=> reason == 3'd7);

endmodule

bind sdram_timing_checker sdram_timing_checker_sva #(
    .BANK_W (BANK_W),
    .CNT_W  (CNT_W)
) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .bank   (bank),
    .t_rrd  (t_rrd),
    .t_ccd  (t_ccd),
    .viol   (viol),
    .reason (reason)
);

// File: tb/sdram_timing_checker_test.sv
// Sweep bench: for each rule, steps the command gap across its limit and
// compares the registered verdict with a code derived from the gap.
module sdram_timing_checker_test;

    localparam int BANK_W = 2;
    localparam int CNT_W  = 6;

    localparam int K_NOP = 0;
    localparam int K_ACT = 1;
    localparam int K_PRE = 2;
    localparam int K_RD  = 3;
    localparam int K_WR  = 4;
    localparam int K_REF = 5;
    localparam int K_DES = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BANK_W-1:0] bank = '0;
    logic [CNT_W-1:0]  t_rcd, t_rrd, t_ccd, t_ras, t_rp, t_rc, add_lat;
    logic              viol;
    logic [2:0]        reason;

    int tests = 0;
    int fails = 0;

    sdram_timing_checker #(.BANK_W(BANK_W), .CNT_W(CNT_W)) uut (
        .clk (clk), .rst_n (rst_n),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .bank (bank),
        .t_rcd (t_rcd), .t_rrd (t_rrd), .t_ccd (t_ccd),
        .t_ras (t_ras), .t_rp (t_rp), .t_rc (t_rc), .add_lat (add_lat),
        .viol (viol), .reason (reason)
    );

    always #10 clk = ~clk;

    task automatic defaults();
        t_rcd = 6'd3; t_rrd = 6'd2; t_ccd = 6'd2; t_ras = 6'd5;
        t_rp = 6'd3;  t_rc = 6'd8;  add_lat = 6'd0;
    endtask

    task automatic drive(input int k, input int b);
        bank = BANK_W'(b);
        case (k)
            K_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            K_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            K_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            K_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            K_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            K_DES:   {cs_n, ras_n, cas_n, we_n} = 4'b1000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
    endtask

    task automatic check(input string tag, input int exp);
        tests++;
        if (reason !== 3'(exp) || viol !== (exp != 0)) begin
            fails++;
            $display("FAIL %s: actual reason=%0d viol=%0b expected reason=%0d viol=%0b",
                     tag, reason, viol, exp, (exp != 0));
        end
    endtask

    // Starts and ends on a falling edge; the verdict is read one cycle on.
    task automatic issue(input int k, input int b, input int exp, input string tag);
        drive(k, b);
        @(negedge clk);
        drive(K_NOP, 0);
        check(tag, exp);
    endtask

    task automatic idle(input int n);
        drive(K_NOP, 0);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(K_NOP, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2: watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        defaults();
        @(negedge clk);
        do_reset();

        // R11: reset state, then the first activate to every bank is legal
        check("R11 reset outputs", 0);
        for (int b = 0; b < 4; b++) begin
            do_reset();
            issue(K_ACT, b, 0, "R11 first activate");
        end

        // R3: activate-to-column with additive latency, gap g
        for (int al = 0; al < 4; al++) begin
            for (int g = 1; g <= 6; g++) begin
                defaults(); add_lat = 6'(al);
                do_reset();
                issue(K_ACT, 0, 0, "R3 setup");
                idle(g - 1);
                issue((g % 2) ? K_WR : K_RD, 0, (g + al < 3) ? 1 : 0, "R3 rcd");
            end
        end

        // R4: different-bank activates; R8: same-bank activates
        for (int g = 1; g <= 9; g++) begin
            defaults();
            do_reset();
            issue(K_ACT, 0, 0, "R4 setup");
            idle(g - 1);
            issue(K_ACT, 1, (g < 2) ? 2 : 0, "R4 rrd");
            do_reset();
            issue(K_ACT, 2, 0, "R8 setup");
            idle(g - 1);
            issue(K_ACT, 2, (g < 8) ? 6 : 0, "R8 rc same bank");
        end

        // R5: column-to-column across banks with t_ccd = 3
        for (int g = 1; g <= 5; g++) begin
            defaults(); t_ccd = 6'd3;
            do_reset();
            issue(K_ACT, 0, 0, "R5 setup");
            idle(3);
            issue(K_ACT, 1, 0, "R5 setup");
            idle(5);
            issue(K_RD, 0, 0, "R5 first column");
            idle(g - 1);
            issue(K_WR, 1, (g < 3) ? 3 : 0, "R5 ccd");
        end

        // R6: activate-to-precharge
        for (int g = 1; g <= 7; g++) begin
            defaults();
            do_reset();
            issue(K_ACT, 2, 0, "R6 setup");
            idle(g - 1);
            issue(K_PRE, 2, (g < 5) ? 4 : 0, "R6 ras");
        end

        // R7: precharge-to-activate, activate long past
        for (int g = 1; g <= 5; g++) begin
            defaults();
            do_reset();
            issue(K_ACT, 1, 0, "R7 setup");
            idle(9);
            issue(K_PRE, 1, 0, "R7 setup");
            idle(g - 1);
            issue(K_ACT, 1, (g < 3) ? 5 : 0, "R7 rp");
        end

        // R8 with R10: t_rc = 12, activate 5 cycles before the precharge
        for (int g = 1; g <= 8; g++) begin
            defaults(); t_rc = 6'd12;
            do_reset();
            issue(K_ACT, 3, 0, "R8 setup");
            idle(4);
            issue(K_PRE, 3, 0, "R8 setup");
            idle(g - 1);
            issue(K_ACT, 3, (g < 3) ? 5 : ((5 + g < 12) ? 6 : 0), "R8 R10 rc after rp");
        end

        // R9: column and precharge to idle banks
        defaults();
        do_reset();
        issue(K_RD, 1, 7, "R9 read closed");
        idle(3);
        issue(K_PRE, 2, 7, "R9 precharge closed");
        idle(3);
        issue(K_WR, 3, 7, "R9 write closed");

        // R10: close column after close column, both tCCD and closed bank
        do_reset();
        issue(K_ACT, 0, 0, "R10 setup");
        idle(3);
        issue(K_RD, 0, 0, "R10 setup");
        issue(K_RD, 1, 3, "R10 ccd beats closed");

        // R1: ignored patterns give no flag and do not restart the activate age
        do_reset();
        issue(K_ACT, 0, 0, "R1 setup");
        issue(K_REF, 1, 0, "R1 refresh pattern");
        issue(K_DES, 2, 0, "R1 deselect");
        issue(K_ACT, 1, 0, "R1 gap from real activate");
        do_reset();
        issue(K_ACT, 0, 0, "R1 setup");
        issue(K_REF, 1, 0, "R1 refresh pattern");
        issue(K_RD, 1, 7, "R1 bank 1 still closed");

        // R12: a flagged activate still restarts the bank's age
        do_reset();
        issue(K_ACT, 0, 0, "R12 setup");
        idle(4);
        issue(K_ACT, 0, 6, "R12 flagged activate");
        issue(K_PRE, 0, 4, "R12 ras from flagged activate");
        issue(K_RD, 0, 7, "R12 precharge closed bank");

        // R2: flag drops on the cycle after a flagged command
        issue(K_NOP, 0, 0, "R2 idle after flag");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule